// File: doc/BRIEF.md
# Configuration Register Shadow Capture

This block watches a time-multiplexed stream of configuration status. On each update, a 7-bit index names one register and a 32-bit data word carries that register's contents. An update is marked by a change of level on a toggle strobe, and either a rising or a falling change counts. The strobe may come from another clock domain. The block synchronises the strobe into its own clock and waits a fixed settling delay. It then samples the index and data and stores the word in a local shadow table of 8 functions by 16 registers.

Downstream logic reads any entry through a combinational read port. The port returns the stored word and a valid flag, which shows that the entry has been captured at least once since reset. After each capture the block emits a one-cycle update pulse together with the index that was written. Logic that only cares about one register can use this pulse to react without polling the table.

Top module: `cfg_shadow_capture`

## Requirements
- R1: While reset is high, and on the first cycle after it, every entry reads as invalid (rd_valid = 0) and upd_pulse is 0.
- R2: A rising change of src_toggle triggers one capture, and a falling change of src_toggle triggers one capture.
- R3: When src_toggle changes between two rising clock edges, the capture happens on the fifth rising edge after that change: two synchroniser stages, one edge-detect stage and two settling cycles. upd_pulse stays 0 after the fourth edge.
- R4: A capture writes entry src_index, read as function = index bits 6:4 and register = index bits 3:0. The read address uses the same encoding, and every other entry keeps its contents.
- R5: An entry's valid flag goes to 1 on its first capture and stays 1 until reset. Entries never captured stay invalid.
- R6: Each capture raises upd_pulse for exactly one cycle, and upd_index then equals the index that was written.
- R7: A later capture to the same entry replaces the stored word.
- R8: While src_toggle holds its level, changes on src_index and src_data write nothing and produce no update pulse.
- R9: The stored word is the value src_data holds at the capture edge, not the value present when the toggle changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| src_index | input | 7 | Stream index: function in bits 6:4, register in bits 3:0 |
| src_data | input | 32 | Stream data word for the indexed register |
| src_toggle | input | 1 | Update strobe; any level change marks new data |
| rd_addr | input | 7 | Shadow table read address, same encoding as src_index |
| rd_data | output | 32 | Stored word at rd_addr (combinational) |
| rd_valid | output | 1 | 1 once the entry at rd_addr has been captured |
| upd_pulse | output | 1 | One-cycle pulse after each capture |
| upd_index | output | 7 | Index written by the capture flagged by upd_pulse |

## Verification
A wrong synchroniser depth or settling count moves upd_pulse by one or more cycles. That shows at the port on the very update that triggers it, because the bench samples the pulse one edge early and on the expected edge. A faulty index decode or write enable leaves a word in the wrong entry, or a valid flag set where it should not be. That stays hidden until that entry is read, so the bench reads every written entry at once and sweeps all 128 entries at the end. A lost edge direction shows as a missing pulse on every other update.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  parameter int FUNC_W = 3;
  parameter int REG_W  = 4;
  parameter int DATA_W = 32;
  localparam int IDX_W = FUNC_W + REG_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    idx_t  idx;
    word_t data;
  } capture_t;
endpackage

// File: rtl/cfg_toggle_sync.sv
module cfg_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic change_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tog_in};
  end

  assign change_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic fire_o
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start_i)   cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  // a fresh change restarts the wait instead of firing
  assign fire_o = (cnt == CNT_W'(1)) && !start_i;
endmodule

// File: rtl/cfg_shadow_table.sv
module cfg_shadow_table #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [(1<<IDX_W)-1:0] valid_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (we) vld[waddr] <= 1'b1;
  end

  assign rdata   = mem[raddr];
  assign rvalid  = vld[raddr];
  assign valid_o = vld;
endmodule

// File: rtl/cfg_shadow_capture.sv
module cfg_shadow_capture
  import cfg_shadow_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  src_index,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_toggle,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              upd_pulse,
  output logic [IDX_W-1:0]  upd_index
);
  localparam int DEPTH = 1 << IDX_W;

  logic             tog_change;
  logic             cap_stb;
  capture_t         cap;
  logic [DEPTH-1:0] valid_q;

  assign cap.idx  = src_index;
  assign cap.data = src_data;

  cfg_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tog_in(src_toggle), .change_o(tog_change)
  );

  cfg_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst(rst), .start_i(tog_change), .fire_o(cap_stb)
  );

  cfg_shadow_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst(rst), .we(cap_stb), .waddr(cap.idx), .wdata(cap.data),
    .raddr(rd_addr), .rdata(rd_data), .rvalid(rd_valid), .valid_o(valid_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_pulse <= 1'b0;
      upd_index <= '0;
    end else begin
      upd_pulse <= cap_stb;
      if (cap_stb) upd_index <= cap.idx;
    end
  end
endmodule

// File: rtl/cfg_shadow_checker.sv
module cfg_shadow_checker #(
  parameter int IDX_W = 7,
  parameter int DEPTH = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_stb,
  input logic [DEPTH-1:0] valid_q,
  input logic             upd_pulse,
  input logic [IDX_W-1:0] upd_index,
  input logic [IDX_W-1:0] rd_addr,
  input logic             rd_valid
);
  // R1: reset clears flags and pulse
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (valid_q == '0 && !upd_pulse));

  // R6: pulse lasts a single cycle
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);

  // R3: pulse only follows a capture strobe
  a_r3_pulse_after_capture: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> !upd_pulse);

  // R5: valid flags never clear outside reset
  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((valid_q & $past(valid_q)) == $past(valid_q)));

  // R8: no capture means no flag change
  a_r8_no_spurious_write: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(valid_q));

  // R4: entry just written reads as valid
  a_r4_written_valid: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse && rd_addr == upd_index) |-> rd_valid);
endmodule

bind cfg_shadow_capture cfg_shadow_checker #(
  .IDX_W(cfg_shadow_pkg::IDX_W), .DEPTH(1 << cfg_shadow_pkg::IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cap_stb(cap_stb), .valid_q(valid_q),
  .upd_pulse(upd_pulse), .upd_index(upd_index),
  .rd_addr(rd_addr), .rd_valid(rd_valid)
);

// File: tb/cfg_shadow_capture_test.sv
`timescale 1ns/1ps
module cfg_shadow_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  src_index = '0;
  logic [31:0] src_data = '0;
  logic        src_toggle = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        upd_pulse;
  logic [6:0]  upd_index;

  int n_chk = 0;
  int n_bad = 0;
  logic        m_valid [128];
  logic [31:0] m_data  [128];

  always #2.5 clk = ~clk;

  cfg_shadow_capture uut (
    .clk(clk), .rst(rst), .src_index(src_index), .src_data(src_data),
    .src_toggle(src_toggle), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .upd_pulse(upd_pulse), .upd_index(upd_index)
  );

  // {index, data}; consecutive entries alternate toggle direction (R2)
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {7'h00, 32'h1111_0000}, {7'h7F, 32'hFFFF_FFFF}, {7'h35, 32'hA5A5_5A5A},
    {7'h40, 32'h0000_0001}, {7'h0F, 32'hDEAD_BEEF}, {7'h70, 32'h1234_5678},
    {7'h35, 32'h0BAD_F00D}, {7'h22, 32'h8000_0000}, {7'h7F, 32'h0000_0000},
    {7'h5A, 32'hCAFE_0042}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one update: toggle flips at a falling edge; capture on 5th rising edge
  task automatic send(input logic [6:0] idx, input logic [31:0] d,
                      input logic [31:0] late_d, input logic use_late);
    @(negedge clk);
    src_index  = idx;
    src_data   = d;
    src_toggle = ~src_toggle;
    if (use_late) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      src_data = late_d;
      repeat (2) @(posedge clk);
    end else begin
      repeat (4) @(posedge clk);
    end
    @(negedge clk);
    check(upd_pulse == 1'b0, "R3 early pulse", {31'd0, upd_pulse}, 32'd0);
    @(negedge clk);
    check(upd_pulse == 1'b1, "R3/R2 pulse on 5th edge", {31'd0, upd_pulse}, 32'd1);
    check(upd_index == idx, "R6 upd_index", {25'd0, upd_index}, {25'd0, idx});
    m_valid[idx] = 1'b1;
    m_data[idx]  = use_late ? late_d : d;
    rd_addr = idx;
    #0.1;
    check(rd_valid == 1'b1, "R5 valid set", {31'd0, rd_valid}, 32'd1);
    check(rd_data === m_data[idx], "R4/R7/R9 stored word", rd_data, m_data[idx]);
    @(negedge clk);
    check(upd_pulse == 1'b0, "R6 pulse width", {31'd0, upd_pulse}, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_valid[i] = 1'b0;
      m_data[i]  = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: after reset nothing is valid and no pulse
    for (int a = 0; a < 128; a += 37) begin
      rd_addr = 7'(a);
      #0.1;
      check(rd_valid == 1'b0, "R1 reset valid", {31'd0, rd_valid}, 32'd0);
    end
    check(upd_pulse == 1'b0, "R1 reset pulse", {31'd0, upd_pulse}, 32'd0);

    // vector table walk (R2..R7)
    for (int v = 0; v < NV; v++)
      send(VEC[v][38:32], VEC[v][31:0], 32'd0, 1'b0);

    // R9: data changes after the toggle, before the capture edge
    send(7'h13, 32'h0000_AAAA, 32'h5555_0000, 1'b1);

    // R8: toggle held, index and data move: no pulse, no write
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      src_index = 7'(k * 9 + 3);
      src_data  = 32'hF0F0_0000 + 32'(k);
      check(upd_pulse == 1'b0, "R8 no pulse without toggle", {31'd0, upd_pulse}, 32'd0);
    end
    repeat (4) @(negedge clk);

    // R4/R5: sweep all entries against the model
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a);
      #0.1;
      check(rd_valid == m_valid[a], "R5 valid sweep", {31'd0, rd_valid}, {31'd0, m_valid[a]});
      if (m_valid[a])
        check(rd_data === m_data[a], "R4 data sweep", rd_data, m_data[a]);
    end

    // R1: reset mid-run clears every flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_addr = 7'h7F;
    #0.1;
    check(rd_valid == 1'b0, "R1 reset clears entry", {31'd0, rd_valid}, 32'd0);
    check(upd_pulse == 1'b0, "R1 reset clears pulse", {31'd0, upd_pulse}, 32'd0);
    summary();
  end
endmodule